// File: doc/BRIEF.md
# Accumulator Pulse-Density Modulator

This block turns an N-bit level into a single-bit pulse stream whose long-run fraction of high cycles equals level / 2^N. It has no period counter and no comparator. An (N+1)-bit register holds an N-bit fractional residue below a carry bit. On every clock the level is added to the residue. The carry out of that addition becomes the new top bit, and the top bit is the output.

The output integrates the level rather than sampling it once per period. A new level can therefore be applied on any clock, and the accumulated number of high cycles still tracks the sum of the levels applied. High cycles are spread as evenly as the resolution allows, which keeps the ripple that a downstream low-pass filter has to remove small. A typical user drives `level_i` from a register or a control loop and feeds `pwm_o` to a filter or a power stage.

Top module: `acc_pwm_top`

## Requirements
- R1: The width parameter `W` defaults to 8. Each clock, the register's lower W bits become (lower W bits + `level_i`) mod 2^W, and bit W takes the carry out of that addition. `pwm_o` is bit W, so a carry produced at one rising edge is visible on `pwm_o` until the next rising edge.
- R2: A synchronous active-high `rst` clears the whole register to zero. `pwm_o` is low while reset is applied and for the first cycle after its release, whatever the level.
- R3: With a constant level D held for any 2^W consecutive clocks, `pwm_o` is high in exactly D of the 2^W cycles that follow those additions.
- R4: A level of 0 gives a permanently low output.
- R5: A level of 2^W-1 gives exactly one low cycle in every 2^W, and never two low cycles in a row.
- R6: The level may change on any clock. Starting from reset, after K clocks with levels D1..DK the number of high output cycles equals floor((D1+...+DK) / 2^W).
- R7: `pwm_o` is high only in a cycle that follows an addition with a nonzero level.
- R8: If the residue is nonzero and the level is 2^W-1, the next output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| level_i | input | W | Requested density, 0 to 2^W-1 |
| pwm_o | output | 1 | Pulse-density output (carry bit of the accumulator) |

## Verification
A table of constant levels is tried: zero, one, two, just below half, half, a high value, and the two values below full scale. For each, the high cycles in one full 2^W window must match the level exactly, which distinguishes an off-by-one carry, a dropped bit or a wrong register width. Separate runs hold the level at 0 and at full scale to check the two extremes. A long run with a level that changes on every clock, and that is zero in about a third of those cycles, is compared against the floor of the summed levels. This run shows whether the output really integrates, as opposed to latching the level at some boundary, and whether any high appears without a preceding nonzero addition. Reset is applied both at start-up and in the middle of a full-scale run.

// File: rtl/acc_pwm_pkg.sv
package acc_pwm_pkg;
    // Default resolution of the level input in bits
    localparam int unsigned ACC_PWM_DEFAULT_W = 8;
endpackage

// File: rtl/acc_pwm_sum.sv
// Combinational step: residue plus level, split into new residue and carry
module acc_pwm_sum #(
    parameter int unsigned W = acc_pwm_pkg::ACC_PWM_DEFAULT_W
) (
    input  logic [W-1:0] frac_i,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] frac_o,
    output logic         carry_o
);
    logic [W:0] total;

    always_comb begin
        total   = {1'b0, frac_i} + {1'b0, level_i};
        frac_o  = total[W-1:0];
        carry_o = total[W];
    end
endmodule

// File: rtl/acc_pwm_reg.sv
// Accumulator storage: W-bit residue plus the carry bit above it
module acc_pwm_reg #(
    parameter int unsigned W = acc_pwm_pkg::ACC_PWM_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] frac_d,
    input  logic         carry_d,
    output logic [W-1:0] frac_q,
    output logic         carry_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q  <= '0;
            carry_q <= 1'b0;
        end else begin
            frac_q  <= frac_d;
            carry_q <= carry_d;
        end
    end
endmodule

// File: rtl/acc_pwm_top.sv
// Pulse-density modulator built from a (W+1)-bit accumulator
module acc_pwm_top #(
    parameter int unsigned W = acc_pwm_pkg::ACC_PWM_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level_i,
    output logic         pwm_o
);
    logic [W-1:0] frac_q;
    logic [W-1:0] frac_d;
    logic         carry_d;
    logic         carry_q;

    acc_pwm_sum #(.W(W)) sum_i (
        .frac_i  (frac_q),
        .level_i (level_i),
        .frac_o  (frac_d),
        .carry_o (carry_d)
    );

    acc_pwm_reg #(.W(W)) reg_i (
        .clk     (clk),
        .rst     (rst),
        .frac_d  (frac_d),
        .carry_d (carry_d),
        .frac_q  (frac_q),
        .carry_q (carry_q)
    );

    assign pwm_o = carry_q;
endmodule

// File: rtl/acc_pwm_chk.sv
// Property checker attached to every acc_pwm_top instance
module acc_pwm_chk #(
    parameter int unsigned W = acc_pwm_pkg::ACC_PWM_DEFAULT_W
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] level_i,
    input logic         pwm_o,
    input logic [W-1:0] frac_q
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pwm_o && frac_q == '0)); // R2

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        (level_i == '0) |=> !pwm_o); // R4

    AST_FULL_CARRY: assert property (@(posedge clk) disable iff (rst)
        (level_i == FULL && frac_q != '0) |=> pwm_o); // R8

    AST_HIGH_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pwm_o) |-> ($past(level_i) != '0)); // R7

    AST_RESIDUE_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (frac_q == W'($past(frac_q) + $past(level_i)))); // R1
endmodule

bind acc_pwm_top acc_pwm_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .level_i (level_i),
    .pwm_o   (pwm_o),
    .frac_q  (frac_q)
);

// File: tb/acc_pwm_tb.sv
module acc_pwm_top_tb_top;
    localparam int W    = 8;
    localparam int SPAN = 1 << W;
    localparam int NVEC = 8;
    localparam int VEC_LVL [NVEC] = '{0, 1, 2, 127, 128, 200, 254, 255};
    localparam int VEC_EXP [NVEC] = '{0, 1, 2, 127, 128, 200, 254, 255};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] level = '0;
    logic         pwm;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    acc_pwm_top #(.W(W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .level_i (level),
        .pwm_o   (pwm)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int highs;
        int lows;
        int run_low;
        int max_run;
        int bad;
        int sum;
        int prev_d;
        logic [15:0] lfsr;

        // R2: reset state with a large level applied
        level = 8'd200;
        repeat (3) @(negedge clk);
        check(pwm == 1'b0, "R2 during reset", int'(pwm), 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwm == 1'b0, "R2 first cycle after reset", int'(pwm), 0);
        // R1: 200+200 overflows on the second addition
        @(negedge clk);
        check(pwm == 1'b1, "R1 carry on second add", int'(pwm), 1);

        // R3: table of constant levels, one full window each
        for (int v = 0; v < NVEC; v++) begin
            level = VEC_LVL[v][W-1:0];
            highs = 0;
            for (int c = 0; c < SPAN; c++) begin
                @(negedge clk);
                if (pwm) highs++;
            end
            check(highs == VEC_EXP[v], $sformatf("R3 level %0d", VEC_LVL[v]), highs, VEC_EXP[v]);
        end

        // R4: zero level stays low
        level = '0;
        bad = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (pwm) bad++;
        end
        check(bad == 0, "R4 zero level high count", bad, 0);

        // R5: full scale, two lows in two windows, never consecutive
        level = '1;
        lows = 0;
        run_low = 0;
        max_run = 0;
        for (int c = 0; c < 2 * SPAN; c++) begin
            @(negedge clk);
            if (!pwm) begin
                lows++;
                run_low++;
                if (run_low > max_run) max_run = run_low;
            end else begin
                run_low = 0;
            end
        end
        check(lows == 2, "R5 full-scale low count", lows, 2);
        check(max_run == 1, "R5 longest low run", max_run, 1);

        // R2: reset in the middle of a full-scale run
        rst = 1'b1;
        @(negedge clk);
        check(pwm == 1'b0, "R2 mid-run reset", int'(pwm), 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwm == 1'b0, "R2 first cycle after mid-run reset", int'(pwm), 0);

        // R6 / R7: level changing every clock, starting from a clean reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lfsr = 16'hACE1;
        sum = 0;
        highs = 0;
        bad = 0;
        for (int c = 0; c < 3000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            prev_d = (lfsr[9:8] == 2'b00 || lfsr[9:8] == 2'b11 && lfsr[0]) ? 0 : int'(lfsr[7:0]);
            level = prev_d[W-1:0];
            sum += prev_d;
            @(negedge clk);
            if (pwm) begin
                highs++;
                if (prev_d == 0) bad++;
            end
        end
        check(highs == sum / SPAN, "R6 integrated high count", highs, sum / SPAN);
        check(bad == 0, "R7 highs after zero level", bad, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule